// File: doc/BRIEF.md
# Walsh Spectral Bit-Stream Analyzer

The analyzer takes a serial stream of test bits applied to one circuit input. It computes the Walsh-Hadamard spectrum of that stream and then separates the components that dominate it from the ones that count as noise. A frame begins with a `start` pulse. The block then accepts exactly N bits through a valid/ready handshake. Each bit becomes +1 or -1. The block transforms the vector in place, one butterfly stage per clock, and finds the average power per component. It then marks dominant components one at a time, strongest first, until the first candidate falls below the programmed threshold.

When the result is final, `done` pulses for one cycle. At that point `coef_flat` holds the N signed coefficients and `ess_mask` flags the components kept as essential. Both outputs hold their values until the next frame starts. A test-generation flow can use this result as the signature of the stream: it keeps the essential components and replaces the rest with fresh noise.

Top module: `walsh_spectrum_analyzer`

## Requirements
- R1: After reset, `bit_ready`, `done`, `ess_mask` and `coef_flat` are all zero.
- R2: A `start` pulse in the idle state raises `bit_ready`. Bits are taken only on cycles where `bit_valid` and `bit_ready` are both high. `bit_ready` drops right after the N-th accepted bit. Bits offered while `bit_ready` is low have no effect on the result.
- R3: An accepted bit of 1 counts as +1 and a bit of 0 counts as -1. The k-th accepted bit is x[k]. Coefficient i equals the sum over k of x[k]·(-1)^popcount(i AND k). It is a COEF_W-bit two's complement value in bits [COEF_W·i+COEF_W-1 : COEF_W·i] of `coef_flat`.
- R4: The average power M² is the floor of (sum of all squared coefficients) divided by N. Component i qualifies when 16·Hi² ≥ K·M², where K is the unsigned value on `k_thresh` with 4 fractional bits.
- R5: Selection visits components in order of falling magnitude, with the lower index first on a tie. It marks each qualifying component in `ess_mask` bit i and ends at the first one that fails. With K = 0, every component is marked.
- R6: `done` is high for exactly one cycle. From that cycle until the next accepted `start`, `ess_mask` and `coef_flat` do not change.
- R7: A `start` pulse raised while a frame is in progress is ignored. The frame still needs N bits and produces the result for those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new frame when idle |
| bit_valid | input | 1 | Stream bit on `bit_data` is offered |
| bit_data | input | 1 | Stream bit, 1 = +1, 0 = -1 |
| bit_ready | output | 1 | Block accepts a stream bit this cycle |
| k_thresh | input | K_W (8) | Threshold factor, unsigned, 4 fractional bits |
| done | output | 1 | One-cycle pulse when results are final |
| coef_flat | output | N·COEF_W (224) | Packed signed spectral coefficients |
| ess_mask | output | N (32) | Essential-component flags |

## Verification
The selection loop is the hardest part to reach from the ports. Its stopping point depends on how K relates to a mix of coefficient magnitudes, and that mix only arises from irregular streams. The bench drives pure Walsh rows, which concentrate all power in one coefficient, and it drives mixed-hex streams that spread power unevenly. It pairs these streams with K values of zero, one, a half and the maximum, so that the loop ends at the first component, part-way through, or only after marking every component. Gapped valid cycles, extra bits after the frame, and a stray `start` mid-frame exercise the handshake corners.

// File: rtl/wsa_pkg.sv
`timescale 1ns/1ps
package wsa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_XFORM,
    ST_POWER,
    ST_PICK,
    ST_DONE
  } wsa_state_e;

  // squared value of one signed coefficient
  function automatic logic [31:0] coef_power(input logic signed [31:0] c);
    return 32'(c * c);
  endfunction

  // threshold test: pwr * 2^frac >= k * avg
  function automatic logic is_essential(input logic [31:0] pwr,
                                        input logic [31:0] k,
                                        input logic [31:0] avg,
                                        input int unsigned frac);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = 64'(pwr) << frac;
    rhs = 64'(k) * 64'(avg);
    return lhs >= rhs;
  endfunction

endpackage

// File: rtl/wsa_fwht_stage.sv
`timescale 1ns/1ps
module wsa_fwht_stage #(
  parameter int N    = 32,
  parameter int W    = 7,
  parameter int SPAN = 1
) (
  input  logic signed [W-1:0] din  [N],
  output logic signed [W-1:0] dout [N]
);
  for (genvar j = 0; j < N; j++) begin : g_bfly
    if ((j & SPAN) == 0) begin : g_sum
      assign dout[j] = din[j] + din[j+SPAN];
    end else begin : g_diff
      assign dout[j] = din[j-SPAN] - din[j];
    end
  end
endmodule

// File: rtl/wsa_fwht_engine.sv
`timescale 1ns/1ps
module wsa_fwht_engine #(
  parameter int N     = 32,
  parameter int W     = 7,
  parameter int LOG2N = 5,
  parameter int STG_W = 3
) (
  input  logic signed [W-1:0] din  [N],
  input  logic [STG_W-1:0]    stage,
  output logic signed [W-1:0] dout [N]
);
  logic signed [W-1:0] stage_out [LOG2N][N];

  for (genvar s = 0; s < LOG2N; s++) begin : g_stage
    wsa_fwht_stage #(.N(N), .W(W), .SPAN(1 << s)) u_stage (
      .din  (din),
      .dout (stage_out[s])
    );
  end

  always_comb begin
    dout = stage_out[0];
    for (int s = 1; s < LOG2N; s++) begin
      if (stage == STG_W'(s)) dout = stage_out[s];
    end
  end
endmodule

// File: rtl/wsa_power.sv
`timescale 1ns/1ps
module wsa_power #(
  parameter int N     = 32,
  parameter int W     = 7,
  parameter int SUM_W = 19
) (
  input  logic signed [W-1:0] coef [N],
  output logic [SUM_W-1:0]    total
);
  import wsa_pkg::*;

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + SUM_W'(coef_power(32'(coef[i])));
    end
  end
endmodule

// File: rtl/wsa_argmax.sv
`timescale 1ns/1ps
module wsa_argmax #(
  parameter int N     = 32,
  parameter int W     = 7,
  parameter int IDX_W = 5,
  parameter int PWR_W = 14
) (
  input  logic signed [W-1:0] coef [N],
  input  logic [N-1:0]        taken,
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output logic [PWR_W-1:0]    pwr
);
  import wsa_pkg::*;

  logic [PWR_W-1:0] cand;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    pwr   = '0;
    cand  = '0;
    for (int i = 0; i < N; i++) begin
      cand = PWR_W'(coef_power(32'(coef[i])));
      // strict compare keeps the lower index on ties
      if (!taken[i] && (!found || cand > pwr)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        pwr   = cand;
      end
    end
  end
endmodule

// File: rtl/walsh_spectrum_analyzer.sv
`timescale 1ns/1ps
module walsh_spectrum_analyzer #(
  parameter int N      = 32,
  parameter int COEF_W = 7,
  parameter int K_W    = 8,
  parameter int K_FRAC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  bit_valid,
  input  logic                  bit_data,
  output logic                  bit_ready,
  input  logic [K_W-1:0]        k_thresh,
  output logic                  done,
  output logic [N*COEF_W-1:0]   coef_flat,
  output logic [N-1:0]          ess_mask
);
  import wsa_pkg::*;

  localparam int LOG2N = $clog2(N);
  localparam int IDX_W = LOG2N;
  localparam int STG_W = $clog2(LOG2N + 1);
  localparam int PWR_W = 2 * COEF_W;
  localparam int SUM_W = PWR_W + LOG2N;

  wsa_state_e           state;
  logic [IDX_W-1:0]     load_cnt;
  logic [STG_W-1:0]     stage_cnt;
  logic signed [COEF_W-1:0] vec      [N];
  logic signed [COEF_W-1:0] fwht_out [N];
  logic [N-1:0]         mask;
  logic [SUM_W-1:0]     avg_pwr;
  logic [SUM_W-1:0]     pwr_sum;

  // named events for the checker
  logic                 pick_found;
  logic [IDX_W-1:0]     pick_idx;
  logic [PWR_W-1:0]     pick_pwr;
  logic                 pick_pass;
  logic                 sel_take;
  logic                 avg_load;

  wsa_fwht_engine #(.N(N), .W(COEF_W), .LOG2N(LOG2N), .STG_W(STG_W)) u_engine (
    .din   (vec),
    .stage (stage_cnt),
    .dout  (fwht_out)
  );

  wsa_power #(.N(N), .W(COEF_W), .SUM_W(SUM_W)) u_power (
    .coef  (vec),
    .total (pwr_sum)
  );

  wsa_argmax #(.N(N), .W(COEF_W), .IDX_W(IDX_W), .PWR_W(PWR_W)) u_argmax (
    .coef  (vec),
    .taken (mask),
    .found (pick_found),
    .idx   (pick_idx),
    .pwr   (pick_pwr)
  );

  assign pick_pass = is_essential(32'(pick_pwr), 32'(k_thresh), 32'(avg_pwr), K_FRAC);
  assign sel_take  = (state == ST_PICK) && pick_found && pick_pass;
  assign avg_load  = (state == ST_POWER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      load_cnt  <= '0;
      stage_cnt <= '0;
      mask      <= '0;
      avg_pwr   <= '0;
      for (int i = 0; i < N; i++) vec[i] <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOAD;
            load_cnt <= '0;
            mask     <= '0;
          end
        end
        ST_LOAD: begin
          if (bit_valid) begin
            vec[load_cnt] <= bit_data ? COEF_W'(1) : {COEF_W{1'b1}};
            load_cnt      <= load_cnt + 1'b1;
            if (load_cnt == IDX_W'(N - 1)) begin
              state     <= ST_XFORM;
              stage_cnt <= '0;
            end
          end
        end
        ST_XFORM: begin
          vec       <= fwht_out;
          stage_cnt <= stage_cnt + 1'b1;
          if (stage_cnt == STG_W'(LOG2N - 1)) state <= ST_POWER;
        end
        ST_POWER: begin
          avg_pwr <= pwr_sum >> LOG2N;
          state   <= ST_PICK;
        end
        ST_PICK: begin
          if (sel_take) mask[pick_idx] <= 1'b1;
          else          state          <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bit_ready = (state == ST_LOAD);
  assign done      = (state == ST_DONE);
  assign ess_mask  = mask;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign coef_flat[i*COEF_W +: COEF_W] = vec[i];
  end
endmodule

// File: rtl/wsa_checker.sv
`timescale 1ns/1ps
module wsa_checker #(
  parameter int N     = 32,
  parameter int SUM_W = 19,
  parameter int PWR_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic [N-1:0]     ess_mask,
  input logic             sel_take,
  input logic [PWR_W-1:0] pick_pwr,
  input logic             avg_load,
  input logic [SUM_W-1:0] avg_pwr
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(ess_mask));

  // R5
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_take |=> $countones(ess_mask) == $past($countones(ess_mask)) + 1);

  // R5
  pick_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_take && $past(sel_take)) |-> pick_pwr <= $past(pick_pwr));

  // R4 (energy of a +/-1 stream of length N averages to N per component)
  avg_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_load |=> avg_pwr == SUM_W'(N));
endmodule

bind walsh_spectrum_analyzer wsa_checker #(.N(N), .SUM_W(SUM_W), .PWR_W(PWR_W)) u_wsa_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .ess_mask (ess_mask),
  .sel_take (sel_take),
  .pick_pwr (pick_pwr),
  .avg_load (avg_load),
  .avg_pwr  (avg_pwr)
);

// File: tb/test_walsh_spectrum_analyzer.sv
`timescale 1ns/1ps
module test_walsh_spectrum_analyzer;
  localparam int N = 32;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready;
  logic [7:0] k_thresh = 8'd16;
  logic done;
  logic [N*CW-1:0] coef_flat;
  logic [N-1:0] ess_mask;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  walsh_spectrum_analyzer i_walsh_spectrum_analyzer (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .k_thresh(k_thresh),
    .done(done), .coef_flat(coef_flat), .ess_mask(ess_mask)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_coef(input logic [N-1:0] bits, input int i);
    int acc = 0;
    for (int k = 0; k < N; k++) begin
      int xv = bits[k] ? 1 : -1;
      acc += ($countones(i & k) % 2 == 1) ? -xv : xv;
    end
    return acc;
  endfunction

  function automatic logic [N-1:0] ref_mask(input logic [N-1:0] bits, input int k);
    int sq [N];
    int total = 0;
    int m2;
    logic [N-1:0] sel = '0;
    for (int i = 0; i < N; i++) begin
      int c = ref_coef(bits, i);
      sq[i] = c * c;
      total += sq[i];
    end
    m2 = total / N;
    for (int r = 0; r < N; r++) begin
      int best = -1;
      for (int i = 0; i < N; i++)
        if (!sel[i] && (best < 0 || sq[i] > sq[best])) best = i;
      if (best < 0) break;
      if (sq[best] * 16 >= k * m2) sel[best] = 1'b1;
      else break;
    end
    return sel;
  endfunction

  // R1
  task automatic t_reset();
    check(bit_ready == 1'b0, "R1", "bit_ready", bit_ready, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(ess_mask == '0, "R1", "ess_mask", ess_mask, 0);
    check(coef_flat == '0, "R1", "coef_flat nonzero", coef_flat != '0, 0);
  endtask

  task automatic run_frame(input logic [N-1:0] bits, input int k, input int gap,
                           input bit poke_start, input string tag);
    int accepted = 0;
    int waited = 0;
    bit seen = 1'b0;
    logic [N-1:0] mask_cap;
    logic [N*CW-1:0] coef_cap;
    int bad_idx = -1;
    int bad_act = 0;
    int bad_exp = 0;
    logic [N-1:0] exp_mask;

    k_thresh = 8'(k);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; accepted < N && cyc < 1000; cyc++) begin
      bit v = (gap == 0) || (cyc % (gap + 1) == 0);
      bit rdy = bit_ready;
      bit_valid = v;
      bit_data  = bits[accepted];
      start     = poke_start && (accepted == 10);
      if (!rdy) check(1'b0, "R2", {tag, " ready low mid-frame"}, rdy, 1);
      @(negedge clk);
      if (v && rdy) accepted++;
    end
    start = 1'b0;
    // extra bits after the frame must be refused and ignored (R2)
    bit_valid = 1'b1;
    bit_data  = ~bits[0];
    check(bit_ready == 1'b0, "R2", {tag, " ready after last bit"}, bit_ready, 0);
    while (!seen && waited < 200) begin
      if (waited == 3) bit_valid = 1'b0;
      if (done) seen = 1'b1;
      else begin @(negedge clk); waited++; end
    end
    bit_valid = 1'b0;
    check(seen, "R6", {tag, " done seen"}, seen, 1);
    mask_cap = ess_mask;
    coef_cap = coef_flat;
    exp_mask = ref_mask(bits, k);
    for (int i = 0; i < N; i++) begin
      int act = int'($signed(coef_cap[i*CW +: CW]));
      int exv = ref_coef(bits, i);
      if (act != exv && bad_idx < 0) begin bad_idx = i; bad_act = act; bad_exp = exv; end
    end
    // R3
    check(bad_idx < 0, "R3", {tag, " coefficient"}, bad_act, bad_exp);
    // R4 R5
    check(mask_cap == exp_mask, "R5", {tag, " ess_mask"}, mask_cap, exp_mask);
    @(negedge clk);
    check(done == 1'b0, "R6", {tag, " done width"}, done, 0);
    repeat (3) @(negedge clk);
    check(ess_mask == mask_cap && coef_flat == coef_cap, "R6",
          {tag, " outputs hold"}, ess_mask, mask_cap);
  endtask

  task automatic t_single_row();
    run_frame(32'hFFFF_FFFF, 16, 0, 1'b0, "all-ones K=1");
    run_frame(32'h5555_5555, 16, 0, 1'b0, "row1 K=1");
  endtask

  task automatic t_k_zero();
    // R5: K = 0 marks everything
    run_frame(32'hDEAD_BEEF, 0, 0, 1'b0, "K=0");
    check(ess_mask == '1, "R5", "K=0 full mask", ess_mask, 32'hFFFF_FFFF);
  endtask

  task automatic t_mixed();
    // R4: threshold partway through the spectrum
    run_frame(32'h0F0F_3C5A, 8, 2, 1'b0, "mixed K=0.5 gapped");
    run_frame(32'h1234_5678, 255, 0, 1'b0, "mixed K=max");
    run_frame(32'hCAFE_0137, 20, 1, 1'b0, "mixed K=1.25 gapped");
  endtask

  task automatic t_start_busy();
    // R7
    run_frame(32'h0000_A5C3, 24, 0, 1'b1, "start mid-frame");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single_row();
    t_k_zero();
    t_mixed();
    t_start_busy();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule